// File: doc/BRIEF.md
# External Bus Ownership Controller

This block decides when a bus master actually drives a shared external bus. An outside arbiter hands the master a grant. The master's own bus sequencer reports three things: whether it has a transfer waiting, whether a transfer is under way, and whether the beat now finishing is the final one of the current access. Software supplies a bus-lock configuration bit.

From these inputs the block keeps one of three ownership states:

- **Released**: no grant.
- **Implicit**: granted, but not driving the bus.
- **Explicit**: driving the bus.

It produces four outputs:

- an active-low "bus driven" indication;
- a bus request to the arbiter;
- one output-enable that releases all master-driven bus signals to high impedance when it is low;
- a permission that tells the sequencer it may start a new transfer.

The grant may vanish while a transfer is running, or while the bus sits idle, and the block handles each case differently. The lock bit lets the master hold explicit ownership through an idle loss of grant. A transfer that is under way always finishes before the bus is released. All state changes on the rising clock edge. Reset is synchronous and active high.

Top module: `bus_own_ctrl`

## Requirements
- R1: While `rst` is 1, the outputs take these values, whatever the other inputs are:
  - `drv_n_o` = 1
  - `req_o` = 0
  - `bus_oe_o` = 0
  - `may_start_o` = 0
- R2: When not in explicit ownership, the block enters explicit ownership at the next rising edge only if two conditions hold:
  - `grant_i` = 1;
  - `pend_i` = 1 or `lock_i` = 1.

  Without `grant_i`, explicit ownership is never entered.
- R3: If `grant_i` = 1 while `pend_i` = 0 and `lock_i` = 0, the block stays out of explicit ownership (implicit ownership). In that case `drv_n_o` = 1 and `bus_oe_o` = 0.
- R4: With `lock_i` = 0, suppose the grant drops while `busy_i` = 1. Explicit ownership then holds through every edge where `busy_i` = 1 and `last_i` = 0. It ends at the edge that follows the cycle with `last_i` = 1, unless grant or lock has returned by then.
- R5: In explicit ownership, suppose all of `grant_i`, `lock_i` and `busy_i` are 0. Explicit ownership then ends at the next rising edge.
- R6: In explicit ownership with `lock_i` = 1, explicit ownership is kept at the next edge, whether or not the grant is present. It ends only at the first edge after `lock_i` returns to 0 with the bus idle.
- R7: `req_o` = 1 exactly when `pend_i` = 1, the block is not in explicit ownership, and `rst` = 0.
- R8: `may_start_o` = 1 only in explicit ownership, and only when `grant_i` = 1 or `lock_i` = 1. It is therefore 0 while a transfer completes after a grant loss.
- R9: `bus_oe_o` is always the inverse of `drv_n_o`.
- R10: Suppose the block is in explicit ownership with `grant_i` = 1 and `lock_i` = 0, and a transfer has just ended or none is running. If `pend_i` = 0, the block falls back to implicit ownership at the next edge, and `drv_n_o` rises to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| grant_i | input | 1 | Bus grant from the arbiter |
| pend_i | input | 1 | A transfer is waiting in the sequencer |
| lock_i | input | 1 | Bus-lock configuration bit |
| busy_i | input | 1 | A transfer is under way on the bus |
| last_i | input | 1 | The current beat is the final one of the access |
| drv_n_o | output | 1 | Active-low: the master drives the bus (explicit ownership) |
| req_o | output | 1 | Bus request to the arbiter |
| bus_oe_o | output | 1 | Output enable for all master-driven bus signals |
| may_start_o | output | 1 | The sequencer may start a new transfer |

## Verification
The bench targets five corner cases. The failure each one catches is:

- **Grant removed mid-access.** A design that released on the grant edge would cut a transfer short. A design that ignored the last-beat flag would keep the bus forever.
- **Idle grant loss with the lock set.** This must hold `drv_n_o` low across several cycles and then release one edge after the lock clears. A design that ignored the lock would release at once.
- **Implicit grant.** The bench checks that a granted but idle master never drives.
- **Grant present, no work left.** The bench checks that ownership falls back to implicit, rather than sticking in explicit.
- **Reset.** Reset is applied while grant and pending are both high. This catches outputs that leak through before the state register clears.

Seeded random stimulus, with a slowly changing lock bit, then runs the bench's reference model against these cases together.

// File: rtl/bus_own_pkg.sv
package bus_own_pkg;

    typedef enum logic [1:0] {
        OWN_RELEASED = 2'd0,
        OWN_IMPLICIT = 2'd1,
        OWN_EXPLICIT = 2'd2
    } own_state_e;

    typedef struct packed {
        logic grant;
        logic pend;
        logic lock;
        logic busy;
        logic last;
    } own_in_t;

    typedef struct packed {
        logic drv_n;
        logic req;
        logic oe;
        logic may_start;
    } own_out_t;

    // Keep explicit ownership while locked, while an access is unfinished,
    // or while granted with more work queued.
    function automatic logic keep_explicit(own_in_t in);
        return in.lock || (in.busy && !in.last) || (in.grant && in.pend);
    endfunction

    // Explicit ownership can only be taken with a grant in hand.
    function automatic logic take_explicit(own_in_t in);
        return in.grant && (in.pend || in.lock);
    endfunction

    function automatic own_state_e own_next(own_state_e cur, own_in_t in);
        logic stay;
        stay = (cur == OWN_EXPLICIT) ? keep_explicit(in) : take_explicit(in);
        if (stay)
            return OWN_EXPLICIT;
        else if (in.grant)
            return OWN_IMPLICIT;
        else
            return OWN_RELEASED;
    endfunction

endpackage

// File: rtl/bus_own_fsm.sv
module bus_own_fsm
    import bus_own_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  own_in_t    in,
    output own_state_e state
);

    own_state_e state_q;

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= OWN_RELEASED;
        else
            state_q <= own_next(state_q, in);
    end

    assign state = state_q;

    // R2: explicit ownership is entered when granted with work or lock
    p_take_r2: assert property (@(posedge clk) disable iff (rst)
        (state_q != OWN_EXPLICIT && in.grant && (in.pend || in.lock))
            |=> state_q == OWN_EXPLICIT);

    // R2: never entered without a grant
    p_no_grab_r2: assert property (@(posedge clk) disable iff (rst)
        (state_q != OWN_EXPLICIT && !in.grant) |=> state_q != OWN_EXPLICIT);

    // R4: an unfinished access keeps the bus
    p_drain_r4: assert property (@(posedge clk) disable iff (rst)
        (state_q == OWN_EXPLICIT && in.busy && !in.last) |=> state_q == OWN_EXPLICIT);

    // R5: idle loss of grant without lock releases at the next edge
    p_idle_release_r5: assert property (@(posedge clk) disable iff (rst)
        (state_q == OWN_EXPLICIT && !in.grant && !in.lock && !in.busy)
            |=> state_q == OWN_RELEASED);

    // R6: lock holds explicit ownership
    p_lock_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q == OWN_EXPLICIT && in.lock) |=> state_q == OWN_EXPLICIT);

    // R3: granted, nothing pending and no lock: never explicit afterwards
    p_implicit_r3: assert property (@(posedge clk) disable iff (rst)
        (state_q != OWN_EXPLICIT && in.grant && !in.pend && !in.lock)
            |=> state_q == OWN_IMPLICIT);

endmodule

// File: rtl/bus_own_outs.sv
module bus_own_outs
    import bus_own_pkg::*;
(
    input  logic       rst,
    input  own_state_e state,
    input  own_in_t    in,
    output own_out_t   out
);

    logic expl;

    always_comb begin
        expl          = (state == OWN_EXPLICIT) && !rst;
        out.drv_n     = !expl;
        out.oe        = expl;
        out.req       = in.pend && !expl && !rst;
        out.may_start = expl && (in.grant || in.lock);
    end

endmodule

// File: rtl/bus_own_ctrl.sv
module bus_own_ctrl
    import bus_own_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic grant_i,
    input  logic pend_i,
    input  logic lock_i,
    input  logic busy_i,
    input  logic last_i,
    output logic drv_n_o,
    output logic req_o,
    output logic bus_oe_o,
    output logic may_start_o
);

    own_in_t    in;
    own_out_t   out;
    own_state_e state;

    assign in = '{grant: grant_i, pend: pend_i, lock: lock_i,
                  busy: busy_i, last: last_i};

    bus_own_fsm u_fsm (
        .clk   (clk),
        .rst   (rst),
        .in    (in),
        .state (state)
    );

    bus_own_outs u_outs (
        .rst   (rst),
        .state (state),
        .in    (in),
        .out   (out)
    );

    assign drv_n_o     = out.drv_n;
    assign req_o       = out.req;
    assign bus_oe_o    = out.oe;
    assign may_start_o = out.may_start;

    // R1: reset quiets every output
    p_rst_quiet_r1: assert property (@(posedge clk)
        rst |-> (drv_n_o && !req_o && !bus_oe_o && !may_start_o));

    // R7: no request while driving
    p_req_r7: assert property (@(posedge clk) disable iff (rst)
        req_o |-> (drv_n_o && pend_i));

    // R8: starting is only allowed while driving
    p_start_r8: assert property (@(posedge clk) disable iff (rst)
        may_start_o |-> !drv_n_o);

    // R9: enable tracks the driven indication
    p_oe_r9: assert property (@(posedge clk) disable iff (rst)
        bus_oe_o != drv_n_o);

endmodule

// File: tb/sim_bus_own_ctrl.sv
module sim_bus_own_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int N_RANDOM   = 3000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic grant_i = 1'b0, pend_i = 1'b0, lock_i = 1'b0, busy_i = 1'b0, last_i = 1'b0;
    logic drv_n_o, req_o, bus_oe_o, may_start_o;

    int n_checks = 0;
    int n_fail   = 0;
    logic m_own  = 1'b0;
    bit   done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_own_ctrl u0 (
        .clk(clk), .rst(rst), .grant_i(grant_i), .pend_i(pend_i), .lock_i(lock_i),
        .busy_i(busy_i), .last_i(last_i), .drv_n_o(drv_n_o), .req_o(req_o),
        .bus_oe_o(bus_oe_o), .may_start_o(may_start_o)
    );

    // Expected {drv_n, req, oe, may_start} from the requirements
    function automatic logic [3:0] exp_outs(logic r, logic own, logic g, logic p, logic l);
        logic e;
        e = own && !r;
        return {!e, p && !e && !r, e, e && (g || l)};
    endfunction

    function automatic logic next_own(logic r, logic own, logic g, logic p, logic l,
                                      logic b, logic la);
        if (r) return 1'b0;
        if (own) return l || (b && !la) || (g && p);
        return g && (p || l);
    endfunction

    // Drive one cycle of inputs, check outputs, advance the model
    task automatic cyc(logic r, logic g, logic p, logic l, logic b, logic la, string tag);
        logic [3:0] exp, act;
        rst = r; grant_i = g; pend_i = p; lock_i = l; busy_i = b; last_i = la;
        #1;
        exp = exp_outs(r, m_own, g, p, l);
        act = {drv_n_o, req_o, bus_oe_o, may_start_o};
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: {drv_n,req,oe,start} actual=%b expected=%b", tag, act, exp);
        end
        m_own = next_own(r, m_own, g, p, l, b, la);
        @(negedge clk);
    endtask

    // Explicit ownership check at the ports
    task automatic chk_own(logic want, string tag);
        n_checks++;
        if (drv_n_o !== !want) begin
            n_fail++;
            $display("FAIL %s: drv_n actual=%b expected=%b", tag, drv_n_o, !want);
        end
    endtask

    initial begin
        logic lk;
        void'($urandom(32'h5EED_1234));
        @(negedge clk);

        // R1: reset with grant and pending high
        cyc(1, 1, 1, 0, 0, 0, "R1 reset");
        cyc(1, 1, 1, 1, 0, 0, "R1 reset");

        // R3: implicit ownership
        cyc(0, 1, 0, 0, 0, 0, "R3 implicit");
        cyc(0, 1, 0, 0, 0, 0, "R3 implicit");
        chk_own(0, "R3 implicit");

        // R2: take explicit ownership
        cyc(0, 1, 1, 0, 0, 0, "R2 take");
        chk_own(1, "R2 take");

        // R4 and R8: grant removed mid-access
        cyc(0, 0, 0, 0, 1, 0, "R4 R8 drain");
        cyc(0, 0, 0, 0, 1, 0, "R4 R8 drain");
        chk_own(1, "R4 drain hold");
        cyc(0, 0, 0, 0, 1, 1, "R4 last beat");
        chk_own(0, "R4 released after last");
        cyc(0, 0, 0, 0, 0, 0, "R4 released");

        // R10: fall back to implicit
        cyc(0, 1, 1, 0, 0, 0, "R2 retake");
        cyc(0, 1, 0, 0, 0, 0, "R10 fallback");
        chk_own(0, "R10 fallback");
        cyc(0, 1, 0, 0, 0, 0, "R10 implicit");

        // R6: lock keeps ownership through idle grant loss
        cyc(0, 1, 0, 1, 0, 0, "R2 lock take");
        cyc(0, 0, 0, 1, 0, 0, "R6 hold");
        cyc(0, 0, 0, 1, 0, 0, "R6 hold");
        cyc(0, 0, 0, 1, 0, 0, "R6 hold");
        chk_own(1, "R6 hold");
        cyc(0, 0, 0, 0, 0, 0, "R6 unlock");
        chk_own(0, "R6 released");

        // R5: idle grant loss without lock
        cyc(0, 1, 1, 0, 0, 0, "R2 take");
        cyc(0, 0, 1, 0, 0, 0, "R5 idle loss");
        chk_own(0, "R5 released");
        cyc(0, 0, 1, 0, 0, 0, "R7 request");

        // Random mix, R7 R9 cover all cycles
        lk = 1'b0;
        for (int i = 0; i < N_RANDOM; i++) begin
            logic g, p, b, la, r;
            if (($urandom % 16) == 0) lk = ~lk;
            r  = (($urandom % 200) == 0);
            g  = ($urandom % 4) != 0;
            p  = $urandom % 2;
            b  = m_own && (($urandom % 3) != 0);
            la = b && (($urandom % 3) == 0);
            cyc(r, g, p, lk, b, la, "R7 R9 random");
        end
        done = 1'b1;
    end

    initial begin
        int k;
        k = 0;
        while (!done && k < 20000) begin
            @(posedge clk);
            k++;
        end
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=done");
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule